// File: doc/BRIEF.md
# Multiplexed LCD Drive Level Sequencer

This block turns the contents of a byte-wide display memory into a stream of level codes, one 3-bit code per LCD pin. An external analog stage uses each code to select a tap on the bias ladder. The block divides a 32 kHz oscillator tick into frames and common time slots. It walks the selected common through the slots and inverts every level on alternate frames so that the panel sees no net DC. The segment pins are driven on or off from the memory bits that belong to the active common.

Two multiplex modes are supported:
- **4-common mode, 1/3 bias, 56 segments.** The four shared pins serve as the lowest segments.
- **8-common mode, 1/4 bias, 52 segments.** The shared pins serve as commons 4 to 7.

The display is lit only when both the oscillator-run bit and the display-enable bit are set. A whole-display blink can be selected at one of three slow rates. The block fetches the memory data through a read port with one cycle of latency. During each slot it prefetches the data for the next slot, so the pin levels change only at slot boundaries.

Top module: `lcd_level_seq`

## Requirements
- R1: While `sys_on` or `disp_en` is low, including during and after reset, every pin code is 0 (top supply). Codes return to 0 one clock after either bit drops.
- R2: Level code k means VLCD − k·Vop/B, where B = 3 in 4-common mode and B = 4 in 8-common mode.
  - In 4-common mode on a frame of polarity 0: the selected common is 3, the other commons are 1, an on segment is 0 and an off segment is 2.
  - On polarity 1: the selected common is 0, the other commons are 2, an on segment is 3 and an off segment is 1.
- R3: In 8-common mode on polarity 0: the selected common is 4, the other commons are 1, an on segment is 0 and an off segment is 2. On polarity 1: the selected common is 0, the other commons are 3, an on segment is 4 and an off segment is 2. No code ever exceeds B.
- R4: In 8-common mode, shared pin i carries common 4+i. In 4-common mode, it carries segment i.
- R5: In 8-common mode, memory row r drives the segment pin numbered r+4 (rows 0 to 51). Bit n of the row is that segment's data for common n, and 1 means on.
- R6: In 4-common mode, only rows 0 to 27 are used. In row r, bit n drives segment 2r and bit 4+n drives segment 2r+1, both for common n.
- R7: Slot length is OSC_HZ/(FRAME_HZ·D) ticks for D commons, and half that when `frame_fast` is 1. All pins stay at code 0 for the first full slot after the display turns on. The first shown slot selects common 0.
- R8: Commons are selected in ascending order, one per slot. The first frame after turn-on has polarity 0, and polarity toggles every frame.
- R9: `blink_sel` works as follows:
  - 00 disables blinking.
  - 01, 10 and 11 toggle the visible phase every OSC_HZ/4, OSC_HZ/2 and OSC_HZ ticks respectively, starting visible.
  - During the hidden phase every segment shows its off code while the commons keep scanning.
  - A phase change takes effect at the first slot boundary after the toggle.
- R10: Pin codes change only at a slot boundary or when the display turns off.
- R11: `ram_rd_addr` never exceeds the last row used by the current mode. A full scan reads every used row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle oscillator tick |
| sys_on | input | 1 | Oscillator run bit |
| disp_en | input | 1 | Display enable bit |
| duty8 | input | 1 | 1 = 8-common mode, 0 = 4-common mode |
| frame_fast | input | 1 | 1 = double frame rate |
| blink_sel | input | 2 | Blink rate select |
| ram_rd_addr | output | AW | Display memory read address |
| ram_rd_data | input | 8 | Read data, one cycle after address |
| com_lvl | output | 12 | Codes of commons 0 to 3, 3 bits each |
| shr_lvl | output | 12 | Codes of the four shared pins |
| seg_lvl | output | 3·N_ROWS | Codes of segment pins 4 and up |

## Verification
The bench sweeps every slot of more than two frames in all four mode and rate combinations, using a different memory pattern each time. At each boundary it compares all sixty pins against levels computed from the memory contents.

Each slot is also sampled one tick before its boundary. This catches a design that updates early, shows the first slot before a full slot has elapsed, or starts on the wrong polarity. A swapped nibble or an off-by-four row mapping would light the wrong segments. Shared pins given the wrong role would leave the upper commons or the lowest segments at the wrong levels.

For blinking, the bench measures the tick count up to the first two visibility changes for every rate. A wrong divider or a blink applied between boundaries would shift these counts. It also confirms that the commons keep scanning while the segments are hidden.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef logic [2:0] lvl_t;

  // code k = VLCD - k*Vop/B; B is 3 (4 commons) or 4 (8 commons)
  function automatic lvl_t bias_top(input logic b4);
    return b4 ? 3'd4 : 3'd3;
  endfunction

  function automatic lvl_t com_code(input logic sel, input logic pol, input logic b4);
    lvl_t b;
    b = bias_top(b4);
    if (sel) return pol ? 3'd0 : b;
    return pol ? (b - 3'd1) : 3'd1;
  endfunction

  function automatic lvl_t seg_code(input logic on, input logic pol, input logic b4);
    lvl_t b;
    b = bias_top(b4);
    if (on) return pol ? b : 3'd0;
    return pol ? (b - 3'd2) : 3'd2;
  endfunction
endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
  parameter int OSC_HZ   = 32000,
  parameter int FRAME_HZ = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic       duty8,
  input  logic       fast,
  input  logic [1:0] blink_sel,
  output logic       bound,
  output logic       scan_go,
  output logic       vis,
  output logic [2:0] nxt_com,
  output logic       nxt_pol
);
  localparam int SLOT_BASE = OSC_HZ / (FRAME_HZ * 4);
  localparam int TW        = $clog2(SLOT_BASE + 1);
  localparam int BW        = $clog2(OSC_HZ + 1);

  logic [TW-1:0] tcnt, len_m1;
  logic [BW-1:0] bcnt, half_m1;
  logic [2:0]    cur, last;
  logic          pol, run_q;

  always_comb begin
    case ({duty8, fast})
      2'b00:          len_m1 = TW'(SLOT_BASE - 1);
      2'b01, 2'b10:   len_m1 = TW'(SLOT_BASE / 2 - 1);
      default:        len_m1 = TW'(SLOT_BASE / 4 - 1);
    endcase
    case (blink_sel)
      2'b01:   half_m1 = BW'(OSC_HZ / 4 - 1);
      2'b10:   half_m1 = BW'(OSC_HZ / 2 - 1);
      default: half_m1 = BW'(OSC_HZ - 1);
    endcase
  end

  assign last    = duty8 ? 3'd7 : 3'd3;
  assign nxt_com = (cur == last) ? 3'd0 : cur + 3'd1;
  assign nxt_pol = (cur == last) ? ~pol : pol;
  assign bound   = run & tick & (tcnt == len_m1);

  // slot / frame sequencing, restarted whenever the display is dark
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tcnt <= '0;
      cur  <= last;
      pol  <= 1'b1;
    end else if (tick) begin
      if (tcnt == len_m1) begin
        tcnt <= '0;
        cur  <= nxt_com;
        pol  <= nxt_pol;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  // prefetch trigger: display turn-on or right after a boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      scan_go <= 1'b0;
    end else begin
      run_q   <= run;
      scan_go <= run & (~run_q | bound);
    end
  end

  // whole-display blink phase
  always_ff @(posedge clk) begin
    if (rst || !run || blink_sel == 2'b00) begin
      bcnt <= '0;
      vis  <= 1'b1;
    end else if (tick) begin
      if (bcnt >= half_m1) begin
        bcnt <= '0;
        vis  <= ~vis;
      end else begin
        bcnt <= bcnt + BW'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_seq_scan.sv
module lcd_seq_scan #(
  parameter int N_ROWS = 52,
  parameter int N_SEG  = N_ROWS + 4,
  parameter int AW     = $clog2(N_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             go,
  input  logic             duty8,
  input  logic [2:0]       com_sel,
  output logic [AW-1:0]    rd_addr,
  input  logic [7:0]       rd_data,
  output logic [N_SEG-1:0] seg_bits
);
  logic          busy, cap_vld;
  logic [AW-1:0] cap_addr, last_row;
  logic [2:0]    com_q;

  assign last_row = duty8 ? AW'(N_ROWS - 1) : AW'(N_SEG / 2 - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      busy    <= 1'b0;
      rd_addr <= '0;
      com_q   <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      rd_addr <= '0;
      com_q   <= com_sel;
    end else if (busy) begin
      if (rd_addr == last_row) begin
        busy    <= 1'b0;
        rd_addr <= '0;
      end else begin
        rd_addr <= rd_addr + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld  <= 1'b0;
      cap_addr <= '0;
    end else begin
      cap_vld  <= busy & run;
      cap_addr <= rd_addr;
    end
  end

  // one shadow bit per segment; each knows which row and bit feed it
  for (genvar n = 0; n < N_SEG; n++) begin : g_seg
    localparam logic ODD  = 1'(n % 2);
    localparam int   ROW4 = n / 2;
    if (n >= 4) begin : g_both
      localparam int ROW8 = n - 4;
      always_ff @(posedge clk) begin
        if (rst) seg_bits[n] <= 1'b0;
        else if (cap_vld) begin
          if (duty8 && cap_addr == AW'(ROW8))
            seg_bits[n] <= rd_data[com_q];
          else if (!duty8 && cap_addr == AW'(ROW4))
            seg_bits[n] <= rd_data[{ODD, com_q[1:0]}];
        end
      end
    end else begin : g_low
      always_ff @(posedge clk) begin
        if (rst) seg_bits[n] <= 1'b0;
        else if (cap_vld && !duty8 && cap_addr == AW'(ROW4))
          seg_bits[n] <= rd_data[{ODD, com_q[1:0]}];
      end
    end
  end
endmodule

// File: rtl/lcd_seq_drive.sv
module lcd_seq_drive
  import lcd_seq_pkg::*;
#(
  parameter int N_ROWS = 52,
  parameter int N_SEG  = N_ROWS + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               bound,
  input  logic               duty8,
  input  logic [2:0]         nxt_com,
  input  logic               nxt_pol,
  input  logic               vis,
  input  logic [N_SEG-1:0]   seg_bits,
  output logic [11:0]        com_lvl,
  output logic [11:0]        shr_lvl,
  output logic [3*N_ROWS-1:0] seg_lvl
);
  for (genvar i = 0; i < 4; i++) begin : g_lo
    always_ff @(posedge clk) begin
      if (rst || !run) begin
        com_lvl[3*i +: 3] <= '0;
        shr_lvl[3*i +: 3] <= '0;
      end else if (bound) begin
        com_lvl[3*i +: 3] <= com_code(nxt_com == 3'(i), nxt_pol, duty8);
        shr_lvl[3*i +: 3] <= duty8 ? com_code(nxt_com == 3'(i + 4), nxt_pol, duty8)
                                   : seg_code(seg_bits[i] & vis, nxt_pol, duty8);
      end
    end
  end

  for (genvar j = 0; j < N_ROWS; j++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst || !run)  seg_lvl[3*j +: 3] <= '0;
      else if (bound)   seg_lvl[3*j +: 3] <= seg_code(seg_bits[j + 4] & vis, nxt_pol, duty8);
    end
  end
endmodule

// File: rtl/lcd_level_seq.sv
module lcd_level_seq #(
  parameter int OSC_HZ   = 32000,
  parameter int FRAME_HZ = 80,
  parameter int N_ROWS   = 52,
  parameter int AW       = $clog2(N_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                sys_on,
  input  logic                disp_en,
  input  logic                duty8,
  input  logic                frame_fast,
  input  logic [1:0]          blink_sel,
  output logic [AW-1:0]       ram_rd_addr,
  input  logic [7:0]          ram_rd_data,
  output logic [11:0]         com_lvl,
  output logic [11:0]         shr_lvl,
  output logic [3*N_ROWS-1:0] seg_lvl
);
  localparam int N_SEG = N_ROWS + 4;

  logic             run, bound, scan_go, vis, nxt_pol;
  logic [2:0]       nxt_com;
  logic [N_SEG-1:0] seg_bits;

  assign run = sys_on & disp_en;

  lcd_seq_timer #(.OSC_HZ(OSC_HZ), .FRAME_HZ(FRAME_HZ)) timer_i (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .duty8(duty8),
    .fast(frame_fast), .blink_sel(blink_sel), .bound(bound),
    .scan_go(scan_go), .vis(vis), .nxt_com(nxt_com), .nxt_pol(nxt_pol)
  );

  lcd_seq_scan #(.N_ROWS(N_ROWS), .N_SEG(N_SEG), .AW(AW)) scan_i (
    .clk(clk), .rst(rst), .run(run), .go(scan_go), .duty8(duty8),
    .com_sel(nxt_com), .rd_addr(ram_rd_addr), .rd_data(ram_rd_data),
    .seg_bits(seg_bits)
  );

  lcd_seq_drive #(.N_ROWS(N_ROWS), .N_SEG(N_SEG)) drive_i (
    .clk(clk), .rst(rst), .run(run), .bound(bound), .duty8(duty8),
    .nxt_com(nxt_com), .nxt_pol(nxt_pol), .vis(vis), .seg_bits(seg_bits),
    .com_lvl(com_lvl), .shr_lvl(shr_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: rtl/lcd_level_seq_chk.sv
module lcd_level_seq_chk #(
  parameter int N_ROWS = 52,
  parameter int AW     = $clog2(N_ROWS)
) (
  input logic                clk,
  input logic                rst,
  input logic                run,
  input logic                bound,
  input logic                duty8,
  input logic [AW-1:0]       ram_rd_addr,
  input logic [11:0]         com_lvl,
  input logic [11:0]         shr_lvl,
  input logic [3*N_ROWS-1:0] seg_lvl
);
  localparam int NP = N_ROWS + 8;

  logic [3*NP-1:0] all_lvl;
  logic [7:0]      sel_hit;
  logic            over_top;
  logic [2:0]      top;

  assign all_lvl = {seg_lvl, shr_lvl, com_lvl};
  assign top     = duty8 ? 3'd4 : 3'd3;

  always_comb begin
    over_top = 1'b0;
    for (int p = 0; p < NP; p++)
      if (all_lvl[3*p +: 3] > top) over_top = 1'b1;
    for (int i = 0; i < 4; i++) begin
      sel_hit[i]     = (com_lvl[3*i +: 3] == top);
      sel_hit[i + 4] = duty8 && (shr_lvl[3*i +: 3] == top);
    end
  end

  p_dark_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (all_lvl == '0));

  p_one_selected_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_hit));

  p_code_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    $stable(duty8) |-> !over_top);

  p_change_on_bound_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(all_lvl) |-> $past(bound || !run));

  p_addr_in_range_r11: assert property (@(posedge clk) disable iff (rst)
    $stable(duty8) |-> (ram_rd_addr <= (duty8 ? AW'(N_ROWS - 1) : AW'((N_ROWS + 4) / 2 - 1))));
endmodule

bind lcd_level_seq lcd_level_seq_chk #(.N_ROWS(N_ROWS), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .run(run), .bound(bound), .duty8(duty8),
  .ram_rd_addr(ram_rd_addr), .com_lvl(com_lvl), .shr_lvl(shr_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_level_seq_tb_top.sv
module lcd_level_seq_tb_top;
  localparam int OSC  = 2560;
  localparam int FR   = 80;
  localparam int ROWS = 52;
  localparam int AW   = $clog2(ROWS);

  logic clk, rst, tick, sys_on, disp_en, duty8, frame_fast;
  logic [1:0]        blink_sel;
  logic [AW-1:0]     ram_rd_addr;
  logic [7:0]        ram_rd_data;
  logic [11:0]       com_lvl, shr_lvl;
  logic [3*ROWS-1:0] seg_lvl;

  logic [7:0] mem [0:63];
  int n_run = 0, n_fail = 0;
  int tp = 9;
  int max_addr = 0;

  lcd_level_seq #(.OSC_HZ(OSC), .FRAME_HZ(FR), .N_ROWS(ROWS)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .sys_on(sys_on), .disp_en(disp_en),
    .duty8(duty8), .frame_fast(frame_fast), .blink_sel(blink_sel),
    .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .com_lvl(com_lvl), .shr_lvl(shr_lvl), .seg_lvl(seg_lvl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_ff @(posedge clk) ram_rd_data <= mem[ram_rd_addr];

  initial begin
    int tc;
    tc = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tc++;
      if (tc >= tp) begin tc = 0; tick = 1'b1; end
      else tick = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (int'(ram_rd_addr) > max_addr) max_addr = int'(ram_rd_addr);
  end

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (tick !== 1'b1);
    end
  endtask

  function automatic logic [2:0] get_pin(input int p);
    if (p < 4) return com_lvl[3*p +: 3];
    if (p < 8) return shr_lvl[3*(p-4) +: 3];
    return seg_lvl[3*(p-8) +: 3];
  endfunction

  // expected code of pin p after the k-th boundary (k = 0: before any)
  function automatic logic [2:0] exp_pin(input int p, input int k, input bit d8, input bit vis);
    int d, s, b, c, sn;
    bit pol, bitv;
    if (k == 0) return 3'd0;
    d = d8 ? 8 : 4;
    b = d8 ? 4 : 3;
    s = (k - 1) % d;
    pol = ((k - 1) / d) % 2;
    c = -1; sn = -1;
    if (p < 4) c = p;
    else if (p < 8) begin if (d8) c = p; else sn = p - 4; end
    else sn = p - 4;
    if (c >= 0) begin
      if (c == s) return pol ? 3'd0 : 3'(b);
      return pol ? 3'(b - 1) : 3'd1;
    end
    bitv = d8 ? mem[sn - 4][s] : mem[sn / 2][(sn % 2) * 4 + s];
    if (bitv && vis) return pol ? 3'(b) : 3'd0;
    return pol ? 3'(b - 2) : 3'd2;
  endfunction

  task automatic check_group(input int lo, input int hi, input int k, input bit d8,
                             input bit vis, input string tag);
    int bad_p;
    logic [2:0] a, e, ba, be;
    bad_p = -1; ba = '0; be = '0;
    n_run++;
    for (int p = lo; p < hi; p++) begin
      a = get_pin(p);
      e = exp_pin(p, k, d8, vis);
      if (a !== e && bad_p < 0) begin bad_p = p; ba = a; be = e; end
    end
    if (bad_p >= 0) begin
      n_fail++;
      $display("FAIL %s: pin %0d slot %0d actual %0d expected %0d", tag, bad_p, k, ba, be);
    end
  endtask

  task automatic check_all(input int k, input bit d8, input bit vis,
                           input string tc, input string ts, input string tg);
    check_group(0, 4, k, d8, vis, tc);
    check_group(4, 8, k, d8, vis, ts);
    check_group(8, ROWS + 8, k, d8, vis, tg);
  endtask

  task automatic check_dark(input string tag);
    check_group(0, ROWS + 8, 0, 1'b0, 1'b1, tag);
  endtask

  task automatic go_dark;
    @(negedge clk);
    sys_on = 1'b0; disp_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < 64; a++)
      mem[a] = 8'((a * 37 + seed * 59 + 13) ^ (a * 3 + seed));
  endtask

  task automatic run_mode(input bit d8, input bit fast, input int seed);
    int len, d, rows;
    go_dark();
    duty8 = d8; frame_fast = fast; blink_sel = 2'b00;
    fill(seed);
    len = (OSC / (FR * 4)) / (d8 ? 2 : 1) / (fast ? 2 : 1);
    d = d8 ? 8 : 4;
    rows = d8 ? ROWS : (ROWS + 4) / 2;
    tp = 60 / (len - 1) + 1;
    max_addr = 0;
    @(negedge clk);
    sys_on = 1'b1; disp_en = 1'b1;
    for (int k = 1; k <= 2 * d + 2; k++) begin
      wait_ticks(len - 1);
      @(negedge clk);
      // R7: nothing before the first full slot; R10: no change inside a slot
      if (k == 1) check_all(0, d8, 1'b1, "R7", "R7", "R7");
      else        check_all(k - 1, d8, 1'b1, "R10", "R10", "R10");
      wait_ticks(1);
      @(negedge clk);
      check_all(k, d8, 1'b1, d8 ? "R3,R8" : "R2,R8", "R4", d8 ? "R5" : "R6");
    end
    // R11: whole used range read, nothing beyond
    n_run++;
    if (max_addr != rows - 1) begin
      n_fail++;
      $display("FAIL R11: max address actual %0d expected %0d", max_addr, rows - 1);
    end
    // R1: display drops mid-run
    @(negedge clk);
    disp_en = 1'b0;
    @(negedge clk);
    check_dark("R1");
  endtask

  task automatic run_blink(input logic [1:0] sel, input int half);
    int t, t1, t2;
    bit v, prev;
    logic [2:0] c;
    go_dark();
    duty8 = 1'b0; frame_fast = 1'b0; blink_sel = sel;
    for (int a = 0; a < 64; a++) mem[a] = 8'hFF;
    tp = 9;
    @(negedge clk);
    sys_on = 1'b1; disp_en = 1'b1;
    t = 0; t1 = -1; t2 = -1; prev = 1'b1;
    while (t2 < 0 && t < 3 * half + 64) begin
      wait_ticks(1);
      t++;
      @(negedge clk);
      c = seg_lvl[2:0];
      v = (c == 3'd0) || (c == 3'd3);
      if (v != prev) begin
        if (t1 < 0) begin
          t1 = t;
          // R9: commons keep scanning while segments are hidden
          check_all(t / 8, 1'b0, 1'b0, "R9", "R9", "R9");
        end else t2 = t;
      end
      prev = v;
    end
    n_run++;
    if (t1 != half + 8) begin
      n_fail++;
      $display("FAIL R9: first hide at tick actual %0d expected %0d", t1, half + 8);
    end
    n_run++;
    if (t2 - t1 != half) begin
      n_fail++;
      $display("FAIL R9: half period actual %0d expected %0d", t2 - t1, half);
    end
  endtask

  initial begin
    #(20 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; sys_on = 1'b0; disp_en = 1'b0; duty8 = 1'b0;
    frame_fast = 1'b0; blink_sel = 2'b00;
    fill(0);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_dark("R1");                       // reset state
    sys_on = 1'b1; disp_en = 1'b0;
    wait_ticks(20); @(negedge clk);
    check_dark("R1");                       // oscillator on, display off
    sys_on = 1'b0; disp_en = 1'b1;
    wait_ticks(20); @(negedge clk);
    check_dark("R1");                       // enable without oscillator

    run_mode(1'b0, 1'b0, 1);
    run_mode(1'b0, 1'b1, 2);
    run_mode(1'b1, 1'b0, 3);
    run_mode(1'b1, 1'b1, 4);

    run_blink(2'b01, OSC / 4);
    run_blink(2'b10, OSC / 2);
    run_blink(2'b11, OSC);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule